// File: doc/BRIEF.md
# Vector Predicate Lookup Unit

This block turns an operand register of a vector-extended scalar core into an element-enable mask and a zeroing mode. It holds two per-register predication tables. One is indexed by integer register number and the other by floating-point register number, so the two register classes are predicated independently. Each table entry can be switched on or off. When it is on, it names an integer register that supplies the mask, and it can ask for that mask to be complemented and for disabled elements to be zeroed.

A lookup gives a register number and a class. In the same cycle the block issues a read on an asynchronous integer register-file port, addressed by the source index of the selected entry. On the next cycle it presents the XLEN-bit mask with a valid strobe and the zeroing flag. The mask width is XLEN, so XLEN also bounds the longest vector the core can run. A scalar operand whose entry is enabled is predicated like any other operand. The only way to exempt an operand is to clear its entry's enable bit. A configuration port writes whole entries. A write takes effect from the following cycle.

Top module: `vpl_lookup`

## Requirements
- R1: While reset is held and on the cycle after it, `rsp_valid` is 0. Reset clears the enable bit of every entry in both tables, so any lookup made before a configuration write returns an all-ones mask.
- R2: A request with `req_valid`=1 at clock edge k produces `rsp_valid`=1 after edge k+1. `rsp_valid` is 1 only in that case. Back-to-back requests produce back-to-back responses in the same order.
- R3: If the selected entry's enable bit is 0, `rsp_mask` is all ones and `rsp_zero` is 0.
- R4: If the selected entry is enabled and its invert bit is 0, `rsp_mask` equals `rf_rd_data` read from the integer register named by the entry's source index during the request cycle.
- R5: If the selected entry is enabled and its invert bit is 1, `rsp_mask` is the bitwise complement of that register's value.
- R6: If the selected entry is enabled, `rsp_zero` equals the entry's zeroing bit.
- R7: `req_class`/`cfg_class` value 0 selects the integer table and 1 selects the floating-point table. A write to entry n of one table leaves entry n of the other table unchanged.
- R8: A floating-point table entry takes its mask from the integer register file, through the same read port, in the same way as an integer entry.
- R9: If a configuration write and a lookup target the same entry in the same cycle, the lookup sees the entry's old contents. A lookup one cycle later sees the new contents.
- R10: In a request cycle `rf_rd_addr` equals the selected entry's source index. `rf_rd_en` is 1 exactly when `req_valid` is 1 and the entry is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Entry write enable |
| cfg_class | input | 1 | Table to write: 0 integer, 1 floating point |
| cfg_idx | input | 5 | Entry number to write |
| cfg_active | input | 1 | New enable bit |
| cfg_zero | input | 1 | New zeroing bit |
| cfg_inv | input | 1 | New invert bit |
| cfg_src | input | 5 | New source integer register index |
| req_valid | input | 1 | Lookup request strobe |
| req_class | input | 1 | Operand class: 0 integer, 1 floating point |
| req_reg | input | 5 | Operand register number |
| rf_rd_en | output | 1 | Integer register-file read enable |
| rf_rd_addr | output | 5 | Integer register-file read address |
| rf_rd_data | input | XLEN | Integer register-file read data (same cycle) |
| rsp_valid | output | 1 | Response strobe |
| rsp_mask | output | XLEN | Element-enable mask |
| rsp_zero | output | 1 | Zeroing mode for disabled elements |

## Verification
The bench sets the same entry number in both tables to different settings and checks that each table keeps its own. A design that shared storage or decoded the class bit wrongly would return the other table's mask. It issues a write and a lookup to the same entry in one cycle. A design that forwarded the write would return the new mask a cycle early. It looks up a floating-point operand whose entry is enabled, and a design that sourced the mask elsewhere would not return the integer register's value. It checks inactive entries after an entry has been disabled again, and after an inverted entry has been used. A design that leaked the invert or zeroing bits into the inactive path would give a mask other than all ones or a zeroing flag other than 0.

// File: rtl/vpl_pkg.sv
package vpl_pkg;

    localparam int unsigned NUM_REGS = 32;
    localparam int unsigned REG_IDX_W = $clog2(NUM_REGS);

    typedef enum logic [0:0] {
        CLS_INT = 1'b0,
        CLS_FP  = 1'b1
    } reg_class_e;

    typedef struct packed {
        logic                 active;
        logic                 zero;
        logic                 inv;
        logic [REG_IDX_W-1:0] src;
    } pred_entry_t;

    typedef struct packed {
        logic                 we;
        logic [REG_IDX_W-1:0] idx;
        pred_entry_t          data;
    } tbl_wr_t;

    // Mask selected by an entry: all ones when disabled, else source (optionally inverted)
    function automatic logic [63:0] form_mask64(input pred_entry_t e, input logic [63:0] v);
        if (!e.active) return '1;
        return e.inv ? ~v : v;
    endfunction

endpackage

// File: rtl/vpl_pred_table.sv
module vpl_pred_table
    import vpl_pkg::*;
#(
    parameter int unsigned ENTRIES = NUM_REGS,
    localparam int unsigned IW = $clog2(ENTRIES)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [IW-1:0] wr_idx,
    input  pred_entry_t  wr_data,
    input  logic [IW-1:0] rd_idx,
    output pred_entry_t  rd_data
);

    logic                 act_q  [ENTRIES];
    logic                 zero_q [ENTRIES];
    logic                 inv_q  [ENTRIES];
    logic [REG_IDX_W-1:0] src_q  [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        logic hit;
        assign hit = wr_en && (wr_idx == IW'(g));

        // only the enable bit needs a reset value
        always_ff @(posedge clk) begin
            if (rst) begin
                act_q[g] <= 1'b0;
            end else if (hit) begin
                act_q[g] <= wr_data.active;
            end
        end

        always_ff @(posedge clk) begin
            if (hit) begin
                zero_q[g] <= wr_data.zero;
                inv_q[g]  <= wr_data.inv;
                src_q[g]  <= wr_data.src;
            end
        end
    end

    // read returns the stored contents; a same-cycle write is not forwarded
    always_comb begin
        rd_data.active = act_q[rd_idx];
        rd_data.zero   = zero_q[rd_idx];
        rd_data.inv    = inv_q[rd_idx];
        rd_data.src    = src_q[rd_idx];
    end

endmodule

// File: rtl/vpl_table_bank.sv
module vpl_table_bank
    import vpl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  reg_class_e wr_class,
    input  tbl_wr_t    wr,
    input  reg_class_e rd_class,
    input  logic [REG_IDX_W-1:0] rd_idx,
    output pred_entry_t rd_data
);

    localparam int unsigned NUM_CLASSES = 2;

    pred_entry_t cls_rd [NUM_CLASSES];

    for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_cls
        logic cls_we;
        assign cls_we = wr.we && (wr_class == reg_class_e'(c));

        vpl_pred_table #(
            .ENTRIES (NUM_REGS)
        ) u_tbl (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (cls_we),
            .wr_idx  (wr.idx),
            .wr_data (wr.data),
            .rd_idx  (rd_idx),
            .rd_data (cls_rd[c])
        );
    end

    always_comb begin
        rd_data = (rd_class == CLS_FP) ? cls_rd[1] : cls_rd[0];
    end

endmodule

// File: rtl/vpl_mask_stage.sv
module vpl_mask_stage
    import vpl_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  pred_entry_t     in_entry,
    input  logic [XLEN-1:0] in_rf,
    output logic            out_valid,
    output logic [XLEN-1:0] out_mask,
    output logic            out_zero
);

    logic [XLEN-1:0] mask_d;
    logic            zero_d;

    always_comb begin
        if (!in_entry.active) begin
            mask_d = '1;
            zero_d = 1'b0;
        end else begin
            mask_d = in_entry.inv ? ~in_rf : in_rf;
            zero_d = in_entry.zero;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_mask <= '0;
            out_zero <= 1'b0;
        end else if (in_valid) begin
            out_mask <= mask_d;
            out_zero <= zero_d;
        end
    end

endmodule

// File: rtl/vpl_lookup.sv
module vpl_lookup
    import vpl_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_we,
    input  logic            cfg_class,
    input  logic [4:0]      cfg_idx,
    input  logic            cfg_active,
    input  logic            cfg_zero,
    input  logic            cfg_inv,
    input  logic [4:0]      cfg_src,
    input  logic            req_valid,
    input  logic            req_class,
    input  logic [4:0]      req_reg,
    output logic            rf_rd_en,
    output logic [4:0]      rf_rd_addr,
    input  logic [XLEN-1:0] rf_rd_data,
    output logic            rsp_valid,
    output logic [XLEN-1:0] rsp_mask,
    output logic            rsp_zero
);

    tbl_wr_t     wr_pkt;
    pred_entry_t sel_entry;

    always_comb begin
        wr_pkt.we          = cfg_we;
        wr_pkt.idx         = cfg_idx;
        wr_pkt.data.active = cfg_active;
        wr_pkt.data.zero   = cfg_zero;
        wr_pkt.data.inv    = cfg_inv;
        wr_pkt.data.src    = cfg_src;
    end

    vpl_table_bank u_bank (
        .clk      (clk),
        .rst      (rst),
        .wr_class (reg_class_e'(cfg_class)),
        .wr       (wr_pkt),
        .rd_class (reg_class_e'(req_class)),
        .rd_idx   (req_reg),
        .rd_data  (sel_entry)
    );

    // predicate source is always an integer register, whatever the operand class
    assign rf_rd_addr = sel_entry.src;
    assign rf_rd_en   = req_valid && sel_entry.active;

    vpl_mask_stage #(
        .XLEN (XLEN)
    ) u_stage (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (req_valid),
        .in_entry  (sel_entry),
        .in_rf     (rf_rd_data),
        .out_valid (rsp_valid),
        .out_mask  (rsp_mask),
        .out_zero  (rsp_zero)
    );

endmodule

// File: rtl/vpl_lookup_chk.sv
module vpl_lookup_chk #(
    parameter int unsigned XLEN = 64
) (
    input logic            clk,
    input logic            rst,
    input logic            req_valid,
    input logic            rf_rd_en,
    input logic [XLEN-1:0] rf_rd_data,
    input logic            rsp_valid,
    input logic [XLEN-1:0] rsp_mask,
    input logic            rsp_zero
);

    a_r1_reset_quiet: assert property (@(posedge clk) rst |=> !rsp_valid);

    a_r2_resp_follows: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    a_r3_inactive_ones: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !rf_rd_en) |=> (rsp_mask == {XLEN{1'b1}} && !rsp_zero));

    a_r4_mask_from_rf: assert property (@(posedge clk) disable iff (rst)
        rf_rd_en |=> (rsp_mask == $past(rf_rd_data) || rsp_mask == ~$past(rf_rd_data)));

    a_r10_read_needs_req: assert property (@(posedge clk) disable iff (rst)
        rf_rd_en |-> req_valid);

endmodule

bind vpl_lookup vpl_lookup_chk #(.XLEN(XLEN)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .rf_rd_en   (rf_rd_en),
    .rf_rd_data (rf_rd_data),
    .rsp_valid  (rsp_valid),
    .rsp_mask   (rsp_mask),
    .rsp_zero   (rsp_zero)
);

// File: tb/vpl_lookup_tb.sv
module vpl_lookup_tb;

    localparam int XLEN = 64;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            cfg_we = 1'b0, cfg_class = 1'b0, cfg_active = 1'b0, cfg_zero = 1'b0, cfg_inv = 1'b0;
    logic [4:0]      cfg_idx = '0, cfg_src = '0;
    logic            req_valid = 1'b0, req_class = 1'b0;
    logic [4:0]      req_reg = '0;
    logic            rf_rd_en;
    logic [4:0]      rf_rd_addr;
    logic [XLEN-1:0] rf_rd_data;
    logic            rsp_valid;
    logic [XLEN-1:0] rsp_mask;
    logic            rsp_zero;

    always #2 clk = ~clk;

    logic [XLEN-1:0] rf_mem [32];
    assign rf_rd_data = rf_mem[rf_rd_addr];

    vpl_lookup #(.XLEN(XLEN)) u_dut (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_class(cfg_class), .cfg_idx(cfg_idx),
        .cfg_active(cfg_active), .cfg_zero(cfg_zero), .cfg_inv(cfg_inv), .cfg_src(cfg_src),
        .req_valid(req_valid), .req_class(req_class), .req_reg(req_reg),
        .rf_rd_en(rf_rd_en), .rf_rd_addr(rf_rd_addr), .rf_rd_data(rf_rd_data),
        .rsp_valid(rsp_valid), .rsp_mask(rsp_mask), .rsp_zero(rsp_zero)
    );

    // reference tables [class][entry]
    logic       m_act  [2][32];
    logic       m_zero [2][32];
    logic       m_inv  [2][32];
    logic [4:0] m_src  [2][32];

    typedef struct {
        logic [XLEN-1:0] mask;
        logic            zero;
        string           tag;
    } exp_t;

    exp_t sb[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   finished = 0;

    task automatic check(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic exp_t predict(input logic cls, input logic [4:0] r, input string tag);
        exp_t e;
        e.tag = tag;
        if (!m_act[cls][r]) begin
            e.mask = '1;
            e.zero = 1'b0;
        end else begin
            e.mask = m_inv[cls][r] ? ~rf_mem[m_src[cls][r]] : rf_mem[m_src[cls][r]];
            e.zero = m_zero[cls][r];
        end
        return e;
    endfunction

    // monitor: compares each response with the oldest expected item
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (sb.size() == 0) begin
                check("R2 unexpected response", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check({e.tag, " mask"}, rsp_mask, e.mask);
                check({e.tag, " zero"}, XLEN'(rsp_zero), XLEN'(e.zero));
            end
        end
    end

    // driver: present a lookup this cycle (caller ends the burst with idle)
    task automatic issue(input logic cls, input logic [4:0] r, input string tag);
        exp_t e;
        @(negedge clk);
        e = predict(cls, r, tag);
        sb.push_back(e);
        cfg_we    = 1'b0;
        req_valid = 1'b1;
        req_class = cls;
        req_reg   = r;
        #1;
        check("R10 rd_en", XLEN'(rf_rd_en), XLEN'(m_act[cls][r]));
        if (m_act[cls][r]) check("R10 rd_addr", XLEN'(rf_rd_addr), XLEN'(m_src[cls][r]));
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
        cfg_we    = 1'b0;
    endtask

    task automatic drive_cfg(input logic cls, input logic [4:0] idx, input logic a,
                             input logic z, input logic i, input logic [4:0] s);
        cfg_we = 1'b1; cfg_class = cls; cfg_idx = idx;
        cfg_active = a; cfg_zero = z; cfg_inv = i; cfg_src = s;
    endtask

    task automatic model_cfg(input logic cls, input logic [4:0] idx, input logic a,
                             input logic z, input logic i, input logic [4:0] s);
        m_act[cls][idx] = a; m_zero[cls][idx] = z; m_inv[cls][idx] = i; m_src[cls][idx] = s;
    endtask

    task automatic set_entry(input logic cls, input logic [4:0] idx, input logic a,
                             input logic z, input logic i, input logic [4:0] s);
        @(negedge clk);
        req_valid = 1'b0;
        drive_cfg(cls, idx, a, z, i, s);
        @(negedge clk);
        cfg_we = 1'b0;
        model_cfg(cls, idx, a, z, i, s);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) begin
            rf_mem[i] = (i == 0) ? '0 : (64'h9E3779B97F4A7C15 * 64'(i + 1)) ^ 64'(i);
            for (int c = 0; c < 2; c++) begin
                m_act[c][i] = 1'b0; m_zero[c][i] = 1'b0; m_inv[c][i] = 1'b0; m_src[c][i] = '0;
            end
        end
        repeat (3) @(negedge clk);
        check("R1 valid in reset", XLEN'(rsp_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 valid after reset", XLEN'(rsp_valid), 0);

        // R1/R3: everything inactive after reset
        issue(1'b0, 5'd3, "R1 int default");
        issue(1'b1, 5'd7, "R1 fp default");
        idle();

        // R4/R6: plain redirect with zeroing
        set_entry(1'b0, 5'd4, 1'b1, 1'b1, 1'b0, 5'd9);
        issue(1'b0, 5'd4, "R4 R6 int redirect");
        idle();
        // R5: inverted
        set_entry(1'b0, 5'd5, 1'b1, 1'b0, 1'b1, 5'd10);
        issue(1'b0, 5'd5, "R5 int inverted");
        idle();

        // R7: fp entry 4 untouched by int write
        issue(1'b1, 5'd4, "R7 fp untouched");
        idle();
        // R8: fp entry sources integer register
        set_entry(1'b1, 5'd4, 1'b1, 1'b1, 1'b1, 5'd12);
        issue(1'b1, 5'd4, "R8 fp from int rf");
        issue(1'b0, 5'd4, "R7 int kept");
        idle();

        // R4: register value change seen on next lookup
        rf_mem[9] = 64'h0123_4567_89AB_CDEF;
        issue(1'b0, 5'd4, "R4 new rf value");
        idle();

        // R9: write and lookup same entry same cycle
        begin
            exp_t e;
            @(negedge clk);
            e = predict(1'b0, 5'd4, "R9 old contents");
            sb.push_back(e);
            drive_cfg(1'b0, 5'd4, 1'b1, 1'b0, 1'b1, 5'd20);
            req_valid = 1'b1; req_class = 1'b0; req_reg = 5'd4;
            @(negedge clk);
            model_cfg(1'b0, 5'd4, 1'b1, 1'b0, 1'b1, 5'd20);
            cfg_we = 1'b0;
            e = predict(1'b0, 5'd4, "R9 new contents");
            sb.push_back(e);
            @(negedge clk);
            req_valid = 1'b0;
        end

        // R3: disable after use, inverted entry disabled
        set_entry(1'b0, 5'd5, 1'b0, 1'b1, 1'b1, 5'd10);
        issue(1'b0, 5'd5, "R3 disabled again");
        idle();

        // R2: back-to-back mixed burst
        set_entry(1'b1, 5'd31, 1'b1, 1'b0, 1'b0, 5'd31);
        set_entry(1'b0, 5'd0,  1'b1, 1'b1, 1'b0, 5'd0);
        issue(1'b1, 5'd31, "R2 burst a");
        issue(1'b0, 5'd0,  "R2 burst b");
        issue(1'b0, 5'd5,  "R2 burst c");
        issue(1'b1, 5'd4,  "R2 burst d");
        issue(1'b0, 5'd4,  "R2 burst e");
        idle();
        repeat (3) @(negedge clk);
        check("R2 all responses seen", XLEN'(sb.size()), 0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule